// File: doc/BRIEF.md
# PCI Master Bus Parity Unit

This block looks after bus parity for the initiator side of a PCI interface. In an address phase or a write data phase, it computes even parity over the low 32 address/data bits and the low four byte-enable bits. It drives that value onto the low-lane parity line one clock later. When the transaction runs 64 bits wide, it does the same for the upper lane on the second parity line. In a read data phase, it captures the expected parity. On the following clock it compares that value with the parity line(s) the target returns.

A read parity mismatch always marks a sticky "parity error detected" status bit. When the parity-response enable is on, the block also pulls its PERR# drive low and records a sticky "master data parity" event. That event is recorded for the block's own PERR# and also when the target signals PERR# back. If the transfer was issued from the processor side, the event also latches a processor-path error flag, and that flag raises the interrupt request. None of this stalls or aborts the transfer: every later phase is driven and checked as usual. Software clears each sticky bit with its own write-one-to-clear strobe.

Top module: `pci_mst_parity`

## Requirements
- R1: In the cycle after a phase coded 1 (address) or 2 (write data), `parOe` is 1 and `parOut` equals the XOR of `cbeN[3:0]` and `adBus[31:0]` from that phase, so the 37 bits hold an even number of ones.
- R2: In the cycle after an address or write phase with `mode64` high, `par64Oe` is 1 and `par64Out` equals the XOR of `cbeN[7:4]` and `adBus[63:32]`. `par64Oe` is 0 in every other cycle.
- R3: In the cycle after a phase coded 0 (idle) or 3 (read data), `parOe` and `par64Oe` are both 0.
- R4: For a read data phase in cycle t, the low-lane parity is compared with `parIn` in cycle t+1. The upper lane is compared with `par64In` only if `mode64` was high in cycle t. A wrong `par64In` in 32-bit mode causes no error.
- R5: A read parity mismatch sets `detParErr` at the clock edge that ends cycle t+1, whatever the state of `parRespEn`.
- R6: `perrN` goes low in cycle t+2 for exactly one clock for each bad read phase, but only if `parRespEn` was high in cycle t+1. Otherwise `perrN` stays high.
- R7: `mstDataPar` is set when `parRespEn` is high and either this block flags a read parity error (same edge as R5) or `tgtPerrN` is low in a cycle c. In the second case the bit is set from cycle c+1.
- R8: `cpuErrFlag` and `irq` are set together with an R7 event when the transfer came from the processor side. For the block's own error, processor origin means `cpuOrigin` was high in the read data phase. For the target's PERR#, it means `cpuOrigin` was high in the cycle where `tgtPerrN` is low.
- R9: Each of `clrDetParErr`, `clrMstDataPar` and `clrCpuErr` clears its own bit in the next cycle. A set and a clear in the same cycle leave the bit at 1.
- R10: A parity error does not hold up the transfer. Back-to-back read phases are each checked, and each produces its own `perrN` pulse. Driving in later phases is unchanged.
- R11: While `rstN` is low, `parOe` and `par64Oe` are 0, `perrN` is 1, and all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phase | input | 2 | 0 idle, 1 address, 2 write data, 3 read data |
| adBus | input | 64 | Address/data value of the current phase |
| cbeN | input | 8 | Command/byte enables of the current phase |
| mode64 | input | 1 | Phase runs 64 bits wide |
| parIn | input | 1 | Low-lane parity returned by the target |
| par64In | input | 1 | Upper-lane parity returned by the target |
| parRespEn | input | 1 | Parity-response enable |
| tgtPerrN | input | 1 | Target PERR# as sampled from the bus, active low |
| cpuOrigin | input | 1 | Transfer was issued from the processor side |
| clrDetParErr | input | 1 | Clear strobe for detParErr |
| clrMstDataPar | input | 1 | Clear strobe for mstDataPar |
| clrCpuErr | input | 1 | Clear strobe for cpuErrFlag |
| parOut | output | 1 | Low-lane parity drive value |
| par64Out | output | 1 | Upper-lane parity drive value |
| parOe | output | 1 | Low-lane parity drive enable |
| par64Oe | output | 1 | Upper-lane parity drive enable |
| perrN | output | 1 | PERR# drive, active low |
| detParErr | output | 1 | Sticky: parity error detected |
| mstDataPar | output | 1 | Sticky: master data parity event |
| cpuErrFlag | output | 1 | Sticky: processor-path parity error |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `phase` holds one of its four codes on each clock. They also assume that every clear strobe is a one-cycle pulse from software and is not tied high. The stimulus drives every input once per clock on the falling edge, with `phase`, `mode64` and `cpuOrigin` valid throughout. It places each returned parity bit in the cycle right after its read data phase. It asserts clear strobes and target PERR# only as sparse single-cycle events, so a sticky bit can be seen holding its value between them.

// File: rtl/par_pkg.sv
package par_pkg;
  parameter int LANES     = 2;
  parameter int LANE_AD_W = 32;
  parameter int LANE_BE_W = 4;
  localparam int AD_W  = LANES * LANE_AD_W;
  localparam int BE_W  = LANES * LANE_BE_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WDATA = 2'd2,
    PH_RDATA = 2'd3
  } phase_e;

  typedef struct packed {
    logic             load;
    logic [LANES-1:0] check;
  } dpStrb_t;
endpackage

// File: rtl/par_datapath.sv
module par_datapath
  import par_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adBus,
  input  logic [BE_W-1:0]  cbeN,
  input  logic [LANES-1:0] parInV,
  input  dpStrb_t          strb,
  output logic [LANES-1:0] parQ,
  output logic [LANES-1:0] laneErr
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lanePar;
    assign lanePar = ^{cbeN[l*LANE_BE_W +: LANE_BE_W], adBus[l*LANE_AD_W +: LANE_AD_W]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          parQ[l] <= 1'b0;
      else if (strb.load) parQ[l] <= lanePar;
    end

    assign laneErr[l] = strb.check[l] & (parInV[l] ^ parQ[l]);
  end
endmodule

// File: rtl/par_control.sv
module par_control
  import par_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       phase,
  input  logic             mode64,
  input  logic             parRespEn,
  input  logic             tgtPerrN,
  input  logic             cpuOrigin,
  input  logic             clrDetParErr,
  input  logic             clrMstDataPar,
  input  logic             clrCpuErr,
  input  logic [LANES-1:0] laneErr,
  output dpStrb_t          strb,
  output logic [LANES-1:0] laneOe,
  output logic             perrN,
  output logic             detParErr,
  output logic             mstDataPar,
  output logic             cpuErrFlag,
  output logic             irq
);
  phase_e phaseE;
  logic   driveQ, readQ, wideQ, cpuQ, perrQ;
  logic   anyErr, mdpSet, cpuSet;

  assign phaseE = phase_e'(phase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ <= 1'b0;
      readQ  <= 1'b0;
      wideQ  <= 1'b0;
      cpuQ   <= 1'b0;
    end else begin
      driveQ <= (phaseE == PH_ADDR) || (phaseE == PH_WDATA);
      readQ  <= (phaseE == PH_RDATA);
      wideQ  <= mode64;
      cpuQ   <= cpuOrigin;
    end
  end

  assign strb.load = (phaseE != PH_IDLE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign strb.check[l] = readQ;
      assign laneOe[l]     = driveQ;
    end else begin : g_wide
      assign strb.check[l] = readQ & wideQ;
      assign laneOe[l]     = driveQ & wideQ;
    end
  end

  assign anyErr = |laneErr;
  assign mdpSet = parRespEn & (anyErr | ~tgtPerrN);
  assign cpuSet = parRespEn & ((anyErr & cpuQ) | (~tgtPerrN & cpuOrigin));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perrQ      <= 1'b0;
      detParErr  <= 1'b0;
      mstDataPar <= 1'b0;
      cpuErrFlag <= 1'b0;
    end else begin
      perrQ      <= anyErr & parRespEn;
      detParErr  <= anyErr | (detParErr  & ~clrDetParErr);
      mstDataPar <= mdpSet | (mstDataPar & ~clrMstDataPar);
      cpuErrFlag <= cpuSet | (cpuErrFlag & ~clrCpuErr);
    end
  end

  assign perrN = ~perrQ;
  assign irq   = cpuErrFlag;
endmodule

// File: rtl/pci_mst_parity.sv
module pci_mst_parity
  import par_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      phase,
  input  logic [AD_W-1:0] adBus,
  input  logic [BE_W-1:0] cbeN,
  input  logic            mode64,
  input  logic            parIn,
  input  logic            par64In,
  input  logic            parRespEn,
  input  logic            tgtPerrN,
  input  logic            cpuOrigin,
  input  logic            clrDetParErr,
  input  logic            clrMstDataPar,
  input  logic            clrCpuErr,
  output logic            parOut,
  output logic            par64Out,
  output logic            parOe,
  output logic            par64Oe,
  output logic            perrN,
  output logic            detParErr,
  output logic            mstDataPar,
  output logic            cpuErrFlag,
  output logic            irq
);
  dpStrb_t          strb;
  logic [LANES-1:0] parQ, laneErr, laneOe;

  par_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .adBus   (adBus),
    .cbeN    (cbeN),
    .parInV  ({par64In, parIn}),
    .strb    (strb),
    .parQ    (parQ),
    .laneErr (laneErr)
  );

  par_control u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .phase         (phase),
    .mode64        (mode64),
    .parRespEn     (parRespEn),
    .tgtPerrN      (tgtPerrN),
    .cpuOrigin     (cpuOrigin),
    .clrDetParErr  (clrDetParErr),
    .clrMstDataPar (clrMstDataPar),
    .clrCpuErr     (clrCpuErr),
    .laneErr       (laneErr),
    .strb          (strb),
    .laneOe        (laneOe),
    .perrN         (perrN),
    .detParErr     (detParErr),
    .mstDataPar    (mstDataPar),
    .cpuErrFlag    (cpuErrFlag),
    .irq           (irq)
  );

  assign parOut   = parQ[0];
  assign par64Out = parQ[1];
  assign parOe    = laneOe[0];
  assign par64Oe  = laneOe[1];
endmodule

// File: rtl/par_checker.sv
module par_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] phase,
  input logic       mode64,
  input logic       parRespEn,
  input logic       clrDetParErr,
  input logic       clrMstDataPar,
  input logic       parOe,
  input logic       par64Oe,
  input logic       perrN,
  input logic       detParErr,
  input logic       mstDataPar,
  input logic       cpuErrFlag,
  input logic       irq
);
  // R2: upper lane never driven alone, and only for a wide phase
  p_wide_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    par64Oe |-> (parOe && $past(mode64)));

  // R3: read or idle phase leaves both drivers off in the next cycle
  p_no_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd0 || phase == 2'd3) |=> (!parOe && !par64Oe));

  // R5: a PERR# pulse always comes with the detected bit
  p_perr_marks_det_r5: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> detParErr);

  // R6: PERR# only when the enable was on in the checking cycle
  p_perr_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> $past(parRespEn));

  // R7: master data parity bit only rises with the enable on
  p_mdp_needs_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mstDataPar) |-> $past(parRespEn));

  // R8: interrupt only with a master data parity event recorded
  p_irq_with_mdp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (mstDataPar && cpuErrFlag));

  // R9: sticky bits hold without a clear
  p_det_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (detParErr && !clrDetParErr) |=> detParErr);

  p_mdp_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mstDataPar && !clrMstDataPar) |=> mstDataPar);

  // R11: reset values
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_vals_r11: assert (!parOe && !par64Oe && perrN && !detParErr &&
                                !mstDataPar && !cpuErrFlag && !irq);
    end
  end
endmodule

bind pci_mst_parity par_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .phase         (phase),
  .mode64        (mode64),
  .parRespEn     (parRespEn),
  .clrDetParErr  (clrDetParErr),
  .clrMstDataPar (clrMstDataPar),
  .parOe         (parOe),
  .par64Oe       (par64Oe),
  .perrN         (perrN),
  .detParErr     (detParErr),
  .mstDataPar    (mstDataPar),
  .cpuErrFlag    (cpuErrFlag),
  .irq           (irq)
);

// File: tb/pci_mst_parity_tb.sv
`timescale 1ns/1ps
module pci_mst_parity_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic [63:0] adBus = '0;
  logic [7:0]  cbeN = '0;
  logic        mode64 = 1'b0, parIn = 1'b0, par64In = 1'b0;
  logic        parRespEn = 1'b0, tgtPerrN = 1'b1, cpuOrigin = 1'b0;
  logic        clrDetParErr = 1'b0, clrMstDataPar = 1'b0, clrCpuErr = 1'b0;
  logic        parOut, par64Out, parOe, par64Oe, perrN;
  logic        detParErr, mstDataPar, cpuErrFlag, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_mst_parity u_dut (.*);

  function automatic bit evenPar(logic [31:0] a, logic [3:0] b);
    int n = 0;
    for (int i = 0; i < 32; i++) n += a[i];
    for (int i = 0; i < 4; i++) n += b[i];
    return n[0];
  endfunction

  // behavioural reference
  bit mParOut, mPar64Out, mParOe, mPar64Oe, mPerrN = 1;
  bit mDet, mMdp, mCpu;
  bit pRead, pWide, pCpu, pLo, pHi;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mParOut = 0; mPar64Out = 0; mParOe = 0; mPar64Oe = 0; mPerrN = 1;
      mDet = 0; mMdp = 0; mCpu = 0; pRead = 0; pWide = 0; pCpu = 0; pLo = 0; pHi = 0;
    end else begin
      bit errLo, errHi, anyErr, setMdp, setCpu;
      errLo  = pRead && (parIn != pLo);
      errHi  = pRead && pWide && (par64In != pHi);
      anyErr = errLo || errHi;
      setMdp = parRespEn && (anyErr || !tgtPerrN);
      setCpu = parRespEn && ((anyErr && pCpu) || (!tgtPerrN && cpuOrigin));
      mPerrN = !(anyErr && parRespEn);
      mDet   = anyErr || (mDet && !clrDetParErr);
      mMdp   = setMdp || (mMdp && !clrMstDataPar);
      mCpu   = setCpu || (mCpu && !clrCpuErr);
      mParOe   = (phase == 2'd1) || (phase == 2'd2);
      mPar64Oe = mParOe && mode64;
      if (phase != 2'd0) begin
        pLo = evenPar(adBus[31:0], cbeN[3:0]);
        pHi = evenPar(adBus[63:32], cbeN[7:4]);
      end
      mParOut = pLo; mPar64Out = pHi;
      pRead = (phase == 2'd3); pWide = mode64; pCpu = cpuOrigin;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    if (mParOe) chk("R1", "parOut", parOut, mParOut);
    chk(mParOe ? "R1" : "R3", "parOe", parOe, mParOe);
    if (mPar64Oe) chk("R2", "par64Out", par64Out, mPar64Out);
    chk("R2", "par64Oe", par64Oe, mPar64Oe);
    chk("R6", "perrN", perrN, mPerrN);
    chk("R5", "detParErr", detParErr, mDet);
    chk("R7", "mstDataPar", mstDataPar, mMdp);
    chk("R8", "cpuErrFlag", cpuErrFlag, mCpu);
    chk("R8", "irq", irq, mCpu);
  endtask

  logic [63:0] lastAd;
  logic [7:0]  lastBe;

  // one clock: compare at the falling edge, then drive the next inputs.
  // flipLo/flipHi corrupt the returned parity that covers the previous phase.
  task automatic cyc(logic [1:0] ph, logic [63:0] ad, logic [7:0] be, bit m64,
                     bit en, bit tgtErr, bit cpu, bit flipLo, bit flipHi,
                     bit cD, bit cM, bit cC);
    @(negedge clk);
    compareAll();
    parIn   = evenPar(lastAd[31:0], lastBe[3:0]) ^ flipLo;
    par64In = evenPar(lastAd[63:32], lastBe[7:4]) ^ flipHi;
    phase = ph; adBus = ad; cbeN = be; mode64 = m64;
    parRespEn = en; tgtPerrN = !tgtErr; cpuOrigin = cpu;
    clrDetParErr = cD; clrMstDataPar = cM; clrCpuErr = cC;
    lastAd = ad; lastBe = be;
  endtask

  task automatic idle(bit en);
    cyc(2'd0, 64'h0, 8'h0, 0, en, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    lastAd = '0; lastBe = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "parOe", parOe, 0);
    chk("R11", "par64Oe", par64Oe, 0);
    chk("R11", "perrN", perrN, 1);
    chk("R11", "detParErr", detParErr, 0);
    chk("R11", "mstDataPar", mstDataPar, 0);
    chk("R11", "irq", irq, 0);
    rstN = 1'b1;
    idle(1);

    // R1/R2: address then wide write
    cyc(2'd1, 64'h0000_0000_1234_5678, 8'hF6, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(2'd2, 64'hDEAD_BEEF_0F0F_0001, 8'h30, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(1); idle(1);

    // R4: 32-bit read with wrong upper parity -> ignored
    cyc(2'd3, 64'h0123_4567_89AB_CDEF, 8'h00, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(2'd0, 64'h0, 8'h0, 0, 1, 0, 0, 0, 1, 0, 0, 0);
    idle(1);
    chk("R4", "detParErr after narrow read", detParErr, 0);
    chk("R4", "perrN after narrow read", perrN, 1);

    // R4/R5: wide read, upper lane bad, response disabled -> det only
    cyc(2'd3, 64'h8000_0001_0000_0003, 8'h11, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(2'd0, 64'h0, 8'h0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle(0);
    chk("R5", "detParErr with enable off", detParErr, 1);
    chk("R6", "perrN with enable off", perrN, 1);
    chk("R7", "mstDataPar with enable off", mstDataPar, 0);

    // R9: clear while no new error
    cyc(2'd0, 64'h0, 8'h0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    idle(1);
    chk("R9", "detParErr cleared", detParErr, 0);

    // R10: back-to-back bad reads, enabled, processor side
    cyc(2'd3, 64'h1111_2222_3333_4444, 8'h05, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc(2'd3, 64'h5555_6666_7777_8888, 8'h0A, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    cyc(2'd2, 64'h0000_0000_CAFE_F00D, 8'h0C, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    chk("R10", "perrN first bad phase", perrN, 0);
    chk("R8", "irq after processor read", irq, 1);
    idle(1);
    chk("R10", "perrN second bad phase", perrN, 0);
    chk("R10", "write still driven", parOe, 1);
    chk("R10", "write parity", parOut, evenPar(32'hCAFE_F00D, 4'hC));
    idle(1);
    chk("R10", "perrN released", perrN, 1);

    // R9: clear and set in the same cycle -> set wins
    cyc(2'd0, 64'h0, 8'h0, 0, 1, 1, 0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R9", "mstDataPar set beats clear", mstDataPar, 1);
    cyc(2'd0, 64'h0, 8'h0, 0, 1, 0, 0, 0, 0, 1, 1, 1);
    idle(1);
    chk("R9", "cpuErrFlag cleared", cpuErrFlag, 0);
    chk("R9", "mstDataPar cleared", mstDataPar, 0);

    // R7/R8: target PERR# from a non-processor transfer
    cyc(2'd0, 64'h0, 8'h0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R7", "mstDataPar from target", mstDataPar, 1);
    chk("R8", "irq stays low", irq, 0);

    // random traffic, compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ph;
      ph = 2'($urandom_range(0, 3));
      cyc(ph, {$urandom, $urandom}, 8'($urandom), 1'($urandom),
          ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) == 0), 1'($urandom),
          ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
          ($urandom_range(0, 9) == 0));
    end
    idle(1); idle(1);
    finishRun();
  end
endmodule